// File: doc/BRIEF.md
# Nibble-RAM Cartridge Bank Controller

This block sits on a cartridge, between a 16-bit processor address bus and an external program ROM. Two address windows cover the ROM. The lower window always shows the first 16 KiB bank. The upper window shows whichever bank the processor last selected, and it selects a bank by writing to a control zone inside the lower window. The block turns each processor address into a physical ROM address and raises a select line while a ROM read is in progress.

The block also holds a small RAM of 512 entries, each 4 bits wide. This RAM appears in a 8 KiB window and repeats every 512 bytes within it. Any read that falls outside that window returns all ones on the block's data output. Inside the window, a read returns the stored nibble with the upper nibble zero. A configuration input gives the number of ROM banks fitted. It must be a power of two from 2 to 16, and the controller folds bank requests into that range.

Top module: `cbc_ctrl`

## Requirements
- R1: After synchronous reset the selected bank is 1, so a read at 0x4000 drives rom_addr 0x04000.
- R2: For cpu_addr in 0x0000–0x3FFF, rom_addr equals cpu_addr zero-extended to 18 bits, whatever bank is selected.
- R3: For cpu_addr in 0x4000–0x7FFF, rom_addr is bank × 0x4000 + cpu_addr[13:0]: bits 17:14 hold the bank and bits 13:0 the window offset.
- R4: A write (cpu_wr high at a clock edge) with cpu_addr in 0x2000–0x3FFF selects bank cpu_wdata[3:0] & (bank_count − 1). Bits 7:4 of the data are ignored. The new bank shows from the next cycle on.
- R5: If that masked value is 0, bank 1 is selected instead. Bank 0 never appears in the upper window.
- R6: Writes to 0x0000–0x1FFF or 0x4000–0x7FFF leave the selected bank unchanged.
- R7: A write in 0xA000–0xBFFF stores cpu_wdata[3:0]. A later read there returns that nibble in rd_data[3:0], with rd_data[7:4] = 0.
- R8: The RAM entry is picked by cpu_addr[8:0], so addresses 512 bytes apart in 0xA000–0xBFFF reach the same entry.
- R9: For any cpu_addr outside 0xA000–0xBFFF, rd_data is 0xFF. rd_data depends only on the address and the stored state, not on cpu_rd.
- R10: rom_sel is high exactly when cpu_rd is high and cpu_addr is below 0x8000. rom_addr is 0 for addresses at or above 0x8000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe, sampled at the clock edge |
| bank_count | input | 5 | Number of ROM banks fitted (2, 4, 8 or 16) |
| rom_addr | output | 18 | Physical ROM address |
| rom_sel | output | 1 | ROM select during reads of 0x0000–0x7FFF |
| rd_data | output | 8 | RAM nibble or 0xFF for undecoded reads |

## Verification
The properties take three things for granted. First, bank_count is a power of two from 2 to 16. Second, it only changes while reset is held. Third, read and write strobes are never high in the same cycle. The stimulus meets all three. It picks bank_count only from the four legal values and changes it only inside a reset sequence. It issues each access as either a one-cycle read or a one-cycle write. Before any random read of the RAM window, the bench writes all 512 RAM entries, so no read returns an unwritten value.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

    localparam int unsigned CPU_AW = 16;

    typedef enum logic [1:0] {
        RGN_ROM_FIXED  = 2'd0,
        RGN_ROM_BANKED = 2'd1,
        RGN_NIB_RAM    = 2'd2,
        RGN_NONE       = 2'd3
    } region_e;

    typedef struct packed {
        region_e region;
        logic    bank_zone;
    } decode_t;

    function automatic decode_t classify(input logic [CPU_AW-1:0] a);
        decode_t d;
        d.bank_zone = (a[15:13] == 3'b001);
        if (a[15:14] == 2'b00)
            d.region = RGN_ROM_FIXED;
        else if (a[15:14] == 2'b01)
            d.region = RGN_ROM_BANKED;
        else if (a[15:13] == 3'b101)
            d.region = RGN_NIB_RAM;
        else
            d.region = RGN_NONE;
        return d;
    endfunction

endpackage

// File: rtl/cbc_decode.sv
module cbc_decode
    import cbc_pkg::*;
(
    input  logic [CPU_AW-1:0] addr,
    output decode_t           dec
);

    always_comb begin
        dec = classify(addr);
    end

endmodule

// File: rtl/cbc_bank_reg.sv
module cbc_bank_reg #(
    parameter int unsigned BANK_W = 4,
    parameter int unsigned CNT_W  = BANK_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BANK_W-1:0] req,
    input  logic [CNT_W-1:0]  count,
    output logic [BANK_W-1:0] bank
);

    localparam logic [BANK_W-1:0] BANK_ONE = BANK_W'(1);

    logic [CNT_W-1:0]  mask_full;
    logic [BANK_W-1:0] folded;
    logic [BANK_W-1:0] next_bank;

    always_comb begin
        mask_full = count - CNT_W'(1);
        folded    = req & mask_full[BANK_W-1:0];
        next_bank = (folded == '0) ? BANK_ONE : folded;
    end

    always_ff @(posedge clk) begin
        if (rst)
            bank <= BANK_ONE;
        else if (load)
            bank <= next_bank;
    end

    logic unused_cnt_top;
    assign unused_cnt_top = mask_full[CNT_W-1];

endmodule

// File: rtl/cbc_nibble_ram.sv
module cbc_nibble_ram #(
    parameter int unsigned DEPTH = 512,
    parameter int unsigned WIDTH = 4,
    parameter int unsigned AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    idx,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            cells[idx] <= wdata;
    end

    assign rdata = cells[idx];

endmodule

// File: rtl/cbc_ctrl.sv
module cbc_ctrl
    import cbc_pkg::*;
#(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned BANK_W    = 4,
    parameter int unsigned WIN_W     = 14,
    parameter int unsigned RAM_DEPTH = 512,
    parameter int unsigned RAM_W     = 4,
    parameter int unsigned CNT_W     = BANK_W + 1,
    parameter int unsigned ROM_AW    = BANK_W + WIN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [CNT_W-1:0]  bank_count,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              rom_sel,
    output logic [DATA_W-1:0] rd_data
);

    localparam int unsigned RAM_AW = $clog2(RAM_DEPTH);

    decode_t           dec;
    logic [BANK_W-1:0] bank;
    logic [RAM_W-1:0]  ram_q;
    logic              bank_load;
    logic              ram_we;
    logic              in_rom;

    cbc_decode u_decode (
        .addr (cpu_addr),
        .dec  (dec)
    );

    assign bank_load = cpu_wr && dec.bank_zone;
    assign ram_we    = cpu_wr && (dec.region == RGN_NIB_RAM);
    assign in_rom    = (dec.region == RGN_ROM_FIXED) || (dec.region == RGN_ROM_BANKED);

    cbc_bank_reg #(
        .BANK_W (BANK_W),
        .CNT_W  (CNT_W)
    ) u_bank (
        .clk   (clk),
        .rst   (rst),
        .load  (bank_load),
        .req   (cpu_wdata[BANK_W-1:0]),
        .count (bank_count),
        .bank  (bank)
    );

    cbc_nibble_ram #(
        .DEPTH (RAM_DEPTH),
        .WIDTH (RAM_W)
    ) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .idx   (cpu_addr[RAM_AW-1:0]),
        .wdata (cpu_wdata[RAM_W-1:0]),
        .rdata (ram_q)
    );

    always_comb begin
        unique case (dec.region)
            RGN_ROM_FIXED:  rom_addr = {{BANK_W{1'b0}}, cpu_addr[WIN_W-1:0]};
            RGN_ROM_BANKED: rom_addr = {bank, cpu_addr[WIN_W-1:0]};
            default:        rom_addr = '0;
        endcase
    end

    assign rom_sel = cpu_rd && in_rom;
    assign rd_data = (dec.region == RGN_NIB_RAM) ? {{(DATA_W-RAM_W){1'b0}}, ram_q} : {DATA_W{1'b1}};

    logic unused_wdata_hi;
    assign unused_wdata_hi = ^cpu_wdata[DATA_W-1:BANK_W];

endmodule

// File: rtl/cbc_ctrl_chk.sv
module cbc_ctrl_chk #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned BANK_W = 4,
    parameter int unsigned WIN_W  = 14,
    parameter int unsigned CNT_W  = BANK_W + 1,
    parameter int unsigned ROM_AW = BANK_W + WIN_W
) (
    input logic              clk,
    input logic              rst,
    input logic [15:0]       cpu_addr,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic              cpu_rd,
    input logic              cpu_wr,
    input logic [CNT_W-1:0]  bank_count,
    input logic [ROM_AW-1:0] rom_addr,
    input logic              rom_sel,
    input logic [DATA_W-1:0] rd_data
);

    logic seen;
    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
    end

    logic lo_win, hi_win, ram_win, bank_zone;
    assign lo_win    = (cpu_addr[15:14] == 2'b00);
    assign hi_win    = (cpu_addr[15:14] == 2'b01);
    assign ram_win   = (cpu_addr[15:13] == 3'b101);
    assign bank_zone = (cpu_addr[15:13] == 3'b001);

    // R1
    a_r1_reset_bank: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && cpu_rd && hi_win) |-> (rom_addr[ROM_AW-1:WIN_W] == BANK_W'(1)));

    // R2
    a_r2_fixed_window: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && lo_win) |-> (rom_addr == ROM_AW'(cpu_addr)));

    // R3
    a_r3_offset_passes: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && hi_win) |-> (rom_addr[WIN_W-1:0] == cpu_addr[WIN_W-1:0]));

    // R4
    a_r4_bank_in_range: assert property (@(posedge clk) disable iff (rst)
        (seen && cpu_rd && hi_win) |-> ((CNT_W'(rom_addr[ROM_AW-1:WIN_W])) < bank_count));

    // R5
    a_r5_bank_never_zero: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && hi_win) |-> (rom_addr[ROM_AW-1:WIN_W] != '0));

    // R6
    a_r6_bank_holds: assert property (@(posedge clk) disable iff (rst)
        (seen && cpu_rd && hi_win && $past(cpu_rd && hi_win) && !$past(cpu_wr && bank_zone))
        |-> (rom_addr[ROM_AW-1:WIN_W] == $past(rom_addr[ROM_AW-1:WIN_W])));

    // R7
    a_r7_upper_nibble_zero: assert property (@(posedge clk) disable iff (rst)
        ram_win |-> (rd_data[DATA_W-1:4] == '0));

    // R8
    a_r8_read_after_write: assert property (@(posedge clk) disable iff (rst)
        (seen && $past(cpu_wr && ram_win) && ram_win && (cpu_addr[8:0] == $past(cpu_addr[8:0])))
        |-> (rd_data[3:0] == $past(cpu_wdata[3:0])));

    // R9
    a_r9_undecoded_ones: assert property (@(posedge clk) disable iff (rst)
        !ram_win |-> (rd_data == '1));

    // R10
    a_r10_select_only_rom_reads: assert property (@(posedge clk) disable iff (rst)
        rom_sel |-> (cpu_rd && !cpu_addr[15]));

    a_r10_upper_addr_zero: assert property (@(posedge clk) disable iff (rst)
        cpu_addr[15] |-> (rom_addr == '0));

endmodule

bind cbc_ctrl cbc_ctrl_chk #(
    .DATA_W (DATA_W),
    .BANK_W (BANK_W),
    .WIN_W  (WIN_W),
    .CNT_W  (CNT_W),
    .ROM_AW (ROM_AW)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .cpu_rd     (cpu_rd),
    .cpu_wr     (cpu_wr),
    .bank_count (bank_count),
    .rom_addr   (rom_addr),
    .rom_sel    (rom_sel),
    .rd_data    (rd_data)
);

// File: tb/test_cbc_ctrl.sv
module test_cbc_ctrl;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [4:0]  bank_count = 5'd16;
    logic [17:0] rom_addr;
    logic        rom_sel;
    logic [7:0]  rd_data;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    logic [3:0] m_bank;
    logic [3:0] m_ram [512];

    always #(CLK_PERIOD/2) clk = ~clk;

    cbc_ctrl i_cbc_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_rd     (cpu_rd),
        .cpu_wr     (cpu_wr),
        .bank_count (bank_count),
        .rom_addr   (rom_addr),
        .rom_sel    (rom_sel),
        .rd_data    (rd_data)
    );

    function automatic logic [3:0] fold(input logic [7:0] d, input logic [4:0] cnt);
        logic [3:0] v;
        v = d[3:0] & 4'(cnt - 5'd1);
        return (v == 4'd0) ? 4'd1 : v;
    endfunction

    function automatic logic [17:0] exp_rom(input logic [15:0] a);
        if (a < 16'h4000)      return {4'd0, a[13:0]};
        else if (a < 16'h8000) return {m_bank, a[13:0]};
        else                   return 18'd0;
    endfunction

    function automatic logic [7:0] exp_rd(input logic [15:0] a);
        if (a >= 16'hA000 && a <= 16'hBFFF) return {4'd0, m_ram[a[8:0]]};
        else                                return 8'hFF;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [4:0] cnt);
        rst = 1'b1;
        bank_count = cnt;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        m_bank = 4'd1;
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d);
        cpu_addr = a;
        cpu_wdata = d;
        cpu_wr = 1'b1;
        @(posedge clk);
        #1;
        cpu_wr = 1'b0;
        if (a[15:13] == 3'b001) m_bank = fold(d, bank_count);
        if (a[15:13] == 3'b101) m_ram[a[8:0]] = d[3:0];
    endtask

    task automatic do_read(input string tag, input logic [15:0] a);
        cpu_addr = a;
        cpu_rd = 1'b1;
        #1;
        chk({tag, " rom_addr"}, 32'(rom_addr), 32'(exp_rom(a)));
        chk({tag, " rd_data"}, 32'(rd_data), 32'(exp_rd(a)));
        chk({tag, " rom_sel"}, 32'(rom_sel), 32'(a < 16'h8000));
        @(posedge clk);
        #1;
        cpu_rd = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0C0FFEE5));
        do_reset(5'd16);

        // R1 reset bank, R9 undecoded reads, R10 select
        do_read("R1", 16'h4000);
        do_read("R9", 16'h8000);
        do_read("R9", 16'hFFFF);
        do_read("R10", 16'hC123);
        // R2 fixed window
        do_read("R2", 16'h1234);
        do_read("R2", 16'h3FFF);

        // R3/R4 bank select, upper data bits ignored
        do_write(16'h2000, 8'h05);
        do_read("R3", 16'h7FFF);
        do_write(16'h2ABC, 8'h3C);
        do_read("R4", 16'h4001);
        // R5 zero remaps to one
        do_write(16'h3FFF, 8'hF0);
        do_read("R5", 16'h5555);
        // R6 other ROM writes ignored
        do_write(16'h2000, 8'h09);
        do_write(16'h1000, 8'h07);
        do_write(16'h6000, 8'h03);
        do_read("R6", 16'h4800);
        do_read("R2", 16'h2100);

        // R4/R5 with four banks fitted
        do_reset(5'd4);
        do_read("R1", 16'h4000);
        do_write(16'h2000, 8'h06);
        do_read("R4", 16'h6000);
        do_write(16'h2000, 8'h04);
        do_read("R5", 16'h6000);

        // fill the RAM so later reads are defined
        for (int i = 0; i < 512; i++) do_write(16'hA000 + 16'(i), 8'($urandom));

        // R7 nibble storage, R8 aliasing
        do_write(16'hA000, 8'hA7);
        do_read("R7", 16'hA000);
        do_read("R8", 16'hA200);
        do_write(16'hBFFF, 8'h5C);
        do_read("R8", 16'hA1FF);
        do_read("R7", 16'hBFFF);

        // constrained random traffic
        for (int it = 0; it < 1200; it++) begin
            logic [15:0] a;
            logic [2:0]  zone;
            if (it % 300 == 0) do_reset(5'd2 << ($urandom % 4));
            zone = 3'($urandom % 6);
            a = 16'($urandom);
            case (zone)
                3'd0: a = {3'b000, a[12:0]};
                3'd1: a = {3'b001, a[12:0]};
                3'd2: a = {2'b01, a[13:0]};
                3'd3: a = {3'b101, a[12:0]};
                default: ;
            endcase
            if ($urandom % 2 == 0) do_write(a, 8'($urandom));
            else if (a < 16'h4000 || a >= 16'h8000) do_read("R9 random", a);
            else do_read("R3 random", a);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule